// File: doc/BRIEF.md
# Operation Group Dispersal Unit

This block takes a stream of 32-bit operation words, one per cycle, and collects consecutive operations into an issue group. A group ends at the operation whose top bit is set. Each operation is decoded into its guard predicate index, opcode, destination register and two source register indices. It is then placed in a free slot that belongs to its functional-unit class. The slot mix is fixed and unequal: two simple integer slots, one complex integer slot, two load/store slots and one branch/compare slot. All four counts are parameters.

Input uses a valid/ready handshake. Output is a single-cycle issue strobe with a valid bit and decoded fields for each slot. A slot that no operation filled issues with its valid bit low, so the operation stream needs no explicit no-ops. If a group holds more operations of one class than that class has slots, the group is split: the collected part issues, and the refused operation opens the next group. An operation whose class code is undefined is consumed without taking a slot, and it raises a one-cycle error flag.

Top module: `opgrp_dispatch`

## Requirements
- R1: Each issued slot carries the fields of its operation word: predicate = bits 30:27, opcode = bits 26:18, destination = bits 17:12, source 1 = bits 11:6, source 2 = bits 5:0. Bit 31 is the group-end (stop) flag and is not issued.
- R2: The class is taken from opcode bits 8:6, which are word bits 26:24: 000 or 001 is simple integer (slots 0..1), 010 is complex integer (slot 2), 011 is load/store (slots 3..4), 100 is branch/compare (slot 5). Slot numbers hold for the default mix.
- R3: Within one class, operations fill that class's slots in arrival order, lowest-numbered slot first.
- R4: When an operation with the stop flag set is accepted, `issue` is high in exactly the next cycle. That cycle carries the stop operation and every earlier operation of the same group. At most one group issues per cycle.
- R5: A `slot_vld` bit is high only while `issue` is high, and only for a slot that an operation filled.
- R6: A legal operation offered while all slots of its class are taken sees `in_ready` low in that cycle. The partial group issues in the next cycle, and in that next cycle the refused operation is accepted as the first operation of a new group.
- R7: An operation with class code 101, 110 or 111 is accepted with `in_ready` high. `err_illegal` goes high for exactly the following cycle, and the operation takes no slot.
- R8: An illegal operation with the stop flag set still ends the group. If no legal operation is pending, the group issues with every `slot_vld` bit low.
- R9: Synchronous active-high reset discards any partly collected group and clears `issue`, `slot_vld` and `err_illegal`.
- R10: While `in_valid` is low, no operation is consumed, `in_ready` stays high and the pending group is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation word offered |
| in_ready | output | 1 | Operation word will be consumed this cycle |
| in_word | input | 32 | Operation word |
| issue | output | 1 | One-cycle group issue strobe |
| err_illegal | output | 1 | Undefined class seen on the previous accepted word |
| slot_vld | output | 6 | Per-slot valid, qualified by issue |
| slot_pred | output | 24 | Per-slot predicate index, 4 bits each |
| slot_opc | output | 54 | Per-slot opcode, 9 bits each |
| slot_dst | output | 36 | Per-slot destination register, 6 bits each |
| slot_src1 | output | 36 | Per-slot first source register, 6 bits each |
| slot_src2 | output | 36 | Per-slot second source register, 6 bits each |

## Verification
Two group-closing causes can arrive in the same cycle: a class overflow and a stop flag on the very word that overflows. The expected result is a split issue of the earlier operations, followed one cycle later by a second issue that holds only the refused word. The second coincidence is an illegal word that carries the stop flag while legal operations are pending. That word must close the group and raise the error flag in the same following cycle, without taking a slot. Both cases are driven on purpose, and they also recur throughout a long pseudo-random stream. Every cycle is compared against an arithmetic slot-occupancy model in the bench.

// File: rtl/opgrp_pkg.sv
`timescale 1ns/1ps
package opgrp_pkg;
   localparam int OP_W   = 32;
   localparam int PRED_W = 4;
   localparam int OPC_W  = 9;
   localparam int REG_W  = 6;
   localparam int CLS_W  = 3;
   localparam int NCLS   = 4;

   localparam logic [CLS_W-1:0] UC_SIMPLE  = 3'd0;
   localparam logic [CLS_W-1:0] UC_CPLX    = 3'd1;
   localparam logic [CLS_W-1:0] UC_LDST    = 3'd2;
   localparam logic [CLS_W-1:0] UC_BRANCH  = 3'd3;
   localparam logic [CLS_W-1:0] UC_ILLEGAL = 3'd4;

   // decoded operation without its stop flag; packing order follows the word
   typedef struct packed {
      logic [PRED_W-1:0] pred;
      logic [OPC_W-1:0]  opc;
      logic [REG_W-1:0]  dst;
      logic [REG_W-1:0]  src1;
      logic [REG_W-1:0]  src2;
   } op_t;
endpackage

// File: rtl/opgrp_decode.sv
`timescale 1ns/1ps
module opgrp_decode
   import opgrp_pkg::*;
(
   input  logic [OP_W-1:0]  word,
   output op_t              op,
   output logic             stop,
   output logic [CLS_W-1:0] cls
);
   logic [2:0] cls_code;

   always_comb begin
      stop     = word[OP_W-1];
      op       = op_t'(word[OP_W-2:0]);
      cls_code = op.opc[OPC_W-1 -: 3];
      unique case (cls_code)
         3'b000, 3'b001: cls = UC_SIMPLE;
         3'b010:         cls = UC_CPLX;
         3'b011:         cls = UC_LDST;
         3'b100:         cls = UC_BRANCH;
         default:        cls = UC_ILLEGAL;
      endcase
   end
endmodule

// File: rtl/opgrp_class_alloc.sv
`timescale 1ns/1ps
module opgrp_class_alloc #(
   parameter int NC   = 2,
   parameter int CNTW = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take,
   input  logic            clr,
   output logic [CNTW-1:0] cnt,
   output logic            full
);
   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (take)  cnt <= cnt + 1'b1;
   end

   assign full = (cnt == CNTW'(NC));

   // R6: a class never holds more operations than it has slots
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNTW'(NC));
   a_r6_no_take_full: assert property (@(posedge clk) disable iff (rst)
      take |-> !full);
endmodule

// File: rtl/opgrp_slot_bank.sv
`timescale 1ns/1ps
module opgrp_slot_bank
   import opgrp_pkg::*;
#(
   parameter int NSLOT = 6,
   parameter int IDXW  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDXW-1:0]  wr_idx,
   input  op_t              wr_op,
   input  logic             close,
   output logic             issue,
   output logic [NSLOT-1:0] out_vld,
   output op_t              out_op [NSLOT]
);
   always_ff @(posedge clk) begin
      if (rst) issue <= 1'b0;
      else     issue <= close;
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic pv;
      logic ov;
      op_t  po;
      op_t  oo;
      logic hit;

      assign hit = wr_en && (wr_idx == IDXW'(i));

      always_ff @(posedge clk) begin
         if (rst) begin
            pv <= 1'b0;
            ov <= 1'b0;
         end else begin
            ov <= close && (pv || hit);
            pv <= close ? 1'b0 : (pv || hit);
         end
      end

      always_ff @(posedge clk) begin
         if (hit)   po <= wr_op;
         if (close) oo <= hit ? wr_op : po;
      end

      assign out_vld[i] = ov;
      assign out_op[i]  = oo;

      // R3: an occupied slot is never written again within a group
      a_r3_no_overwrite: assert property (@(posedge clk) disable iff (rst)
         hit |-> !pv);
   end

   // R5: slot valid only accompanies the issue strobe
   a_r5_vld_with_issue: assert property (@(posedge clk) disable iff (rst)
      (|out_vld) |-> issue);
endmodule

// File: rtl/opgrp_dispatch.sv
`timescale 1ns/1ps
module opgrp_dispatch
   import opgrp_pkg::*;
#(
   parameter int N_SIMPLE = 2,
   parameter int N_CPLX   = 1,
   parameter int N_LDST   = 2,
   parameter int N_BRANCH = 1,
   localparam int NSLOT   = N_SIMPLE + N_CPLX + N_LDST + N_BRANCH
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [OP_W-1:0]         in_word,
   output logic                    issue,
   output logic                    err_illegal,
   output logic [NSLOT-1:0]        slot_vld,
   output logic [NSLOT*PRED_W-1:0] slot_pred,
   output logic [NSLOT*OPC_W-1:0]  slot_opc,
   output logic [NSLOT*REG_W-1:0]  slot_dst,
   output logic [NSLOT*REG_W-1:0]  slot_src1,
   output logic [NSLOT*REG_W-1:0]  slot_src2
);
   localparam int CNTW = 3;
   localparam int IDXW = $clog2(NSLOT + 1);

   function automatic int cls_n(input int c);
      case (c)
         0:       return N_SIMPLE;
         1:       return N_CPLX;
         2:       return N_LDST;
         default: return N_BRANCH;
      endcase
   endfunction

   function automatic int cls_base(input int c);
      int s;
      s = 0;
      for (int k = 0; k < c; k++) s += cls_n(k);
      return s;
   endfunction

   if (N_SIMPLE < 1 || N_CPLX < 1 || N_LDST < 1 || N_BRANCH < 1 ||
       N_SIMPLE > 7 || N_CPLX > 7 || N_LDST > 7 || N_BRANCH > 7) begin : g_bad_mix
      $error("opgrp_dispatch: each class needs 1 to 7 slots");
   end

   op_t                        dec_op;
   logic                       dec_stop;
   logic [CLS_W-1:0]           dec_cls;
   logic                       legal;
   logic                       cls_full;
   logic                       acc;
   logic                       wr_en;
   logic                       close;
   logic [IDXW-1:0]            wr_idx;
   logic [NCLS-1:0][CNTW-1:0]  cnt_v;
   logic [NCLS-1:0]            full_v;
   logic [NCLS-1:0][IDXW-1:0]  base_v;
   op_t                        out_op [NSLOT];

   opgrp_decode u_dec (
      .word (in_word),
      .op   (dec_op),
      .stop (dec_stop),
      .cls  (dec_cls)
   );

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      localparam int NC = cls_n(c);
      opgrp_class_alloc #(.NC(NC), .CNTW(CNTW)) u_alloc (
         .clk  (clk),
         .rst  (rst),
         .take (wr_en && (dec_cls == CLS_W'(c))),
         .clr  (close),
         .cnt  (cnt_v[c]),
         .full (full_v[c])
      );
      assign base_v[c] = IDXW'(cls_base(c));
   end

   assign legal    = (dec_cls != UC_ILLEGAL);
   assign cls_full = legal && full_v[dec_cls[1:0]];
   assign in_ready = !(in_valid && cls_full);
   assign acc      = in_valid && in_ready;
   assign wr_en    = acc && legal;
   assign wr_idx   = base_v[dec_cls[1:0]] + IDXW'(cnt_v[dec_cls[1:0]]);
   assign close    = (in_valid && cls_full) || (acc && dec_stop);

   opgrp_slot_bank #(.NSLOT(NSLOT), .IDXW(IDXW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_op   (dec_op),
      .close   (close),
      .issue   (issue),
      .out_vld (slot_vld),
      .out_op  (out_op)
   );

   always_ff @(posedge clk) begin
      if (rst) err_illegal <= 1'b0;
      else     err_illegal <= acc && !legal;
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_flat
      assign slot_pred[i*PRED_W +: PRED_W] = out_op[i].pred;
      assign slot_opc[i*OPC_W +: OPC_W]    = out_op[i].opc;
      assign slot_dst[i*REG_W +: REG_W]    = out_op[i].dst;
      assign slot_src1[i*REG_W +: REG_W]   = out_op[i].src1;
      assign slot_src2[i*REG_W +: REG_W]   = out_op[i].src2;
   end

   // R6: a refused word forces a split issue in the next cycle
   a_r6_split_issue: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_ready) |=> issue);
   // R4: an accepted stop word is followed by the issue strobe
   a_r4_stop_issue: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_word[OP_W-1]) |=> issue);
   // R7: the error flag only follows an accepted word
   a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
      err_illegal |-> $past(in_valid && in_ready));
   // R7: an illegal word is never refused
   a_r7_illegal_ready: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !legal) |-> in_ready);
endmodule

// File: tb/opgrp_dispatch_tb_top.sv
`timescale 1ns/1ps
module opgrp_dispatch_tb_top;
   localparam int NS = 6;
   localparam int NCL [4] = '{2, 1, 2, 1};
   localparam int BAS [4] = '{0, 2, 3, 5};

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic          in_ready;
   logic [31:0]   in_word;
   logic          issue;
   logic          err_illegal;
   logic [NS-1:0] slot_vld;
   logic [NS*4-1:0] slot_pred;
   logic [NS*9-1:0] slot_opc;
   logic [NS*6-1:0] slot_dst;
   logic [NS*6-1:0] slot_src1;
   logic [NS*6-1:0] slot_src2;

   always #2.5 clk = ~clk;

   opgrp_dispatch dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .issue(issue), .err_illegal(err_illegal),
      .slot_vld(slot_vld), .slot_pred(slot_pred), .slot_opc(slot_opc),
      .slot_dst(slot_dst), .slot_src1(slot_src1), .slot_src2(slot_src2)
   );

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;
   string cur = "R1";

   int          cnt [4];
   bit          pv [NS];
   logic [31:0] pw [NS];
   bit          ev [NS];
   logic [31:0] ew [NS];
   bit          exp_issue;
   bit          exp_err;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   function automatic int cls_of(input logic [31:0] w);
      case (w[26:24])
         3'd0, 3'd1: return 0;
         3'd2:       return 1;
         3'd3:       return 2;
         3'd4:       return 3;
         default:    return 4;
      endcase
   endfunction

   function automatic logic [31:0] mk(input bit s, input logic [2:0] cc, input logic [31:0] r);
      return {s, r[30:27], cc, r[23:0]};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s (%s case) %s: actual=%h expected=%h", tag, cur, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NS; i++) pv[i] = 1'b0;
      for (int c = 0; c < 4; c++) cnt[c] = 0;
   endtask

   task automatic snapshot();
      for (int i = 0; i < NS; i++) begin
         ev[i] = pv[i];
         ew[i] = pw[i];
      end
      exp_issue = 1'b1;
      model_clear();
   endtask

   task automatic check_outputs();
      chk("R4", "issue", 32'(issue), 32'(exp_issue));
      chk("R7", "err_illegal", 32'(err_illegal), 32'(exp_err));
      for (int i = 0; i < NS; i++) begin
         chk("R5", $sformatf("slot_vld[%0d]", i), 32'(slot_vld[i]), 32'(exp_issue && ev[i]));
         if (exp_issue && ev[i]) begin
            chk("R1", "pred", 32'(slot_pred[i*4 +: 4]), 32'(ew[i][30:27]));
            chk("R2", "opcode", 32'(slot_opc[i*9 +: 9]), 32'(ew[i][26:18]));
            chk("R3", "dst", 32'(slot_dst[i*6 +: 6]), 32'(ew[i][17:12]));
            chk("R1", "src1", 32'(slot_src1[i*6 +: 6]), 32'(ew[i][11:6]));
            chk("R1", "src2", 32'(slot_src2[i*6 +: 6]), 32'(ew[i][5:0]));
         end
      end
   endtask

   task automatic step(input bit v, input logic [31:0] w, output bit acc);
      int c;
      bit full;
      @(negedge clk);
      in_valid = v;
      in_word  = w;
      #1;
      check_outputs();
      c = cls_of(w);
      full = (c < 4) && (cnt[c] == NCL[c]);
      chk("R6", "in_ready", 32'(in_ready), 32'(!(v && full)));
      exp_issue = 1'b0;
      exp_err   = 1'b0;
      acc       = 1'b0;
      if (v && full) begin
         snapshot();
      end else if (v) begin
         acc = 1'b1;
         if (c == 4) exp_err = 1'b1;
         else begin
            pv[BAS[c] + cnt[c]] = 1'b1;
            pw[BAS[c] + cnt[c]] = w;
            cnt[c]++;
         end
         if (w[31]) snapshot();
      end
   endtask

   task automatic send(input logic [31:0] w);
      bit a;
      a = 1'b0;
      for (int k = 0; k < 4 && !a; k++) step(1'b1, w, a);
      if (!a) chk("R6", "word never accepted", 32'd0, 32'd1);
   endtask

   task automatic idle();
      bit a;
      step(1'b0, 32'h0, a);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      in_word = '0;
      @(negedge clk);
      #1;
      cur = "R9";
      chk("R9", "issue in reset", 32'(issue), 32'd0);
      chk("R9", "slot_vld in reset", 32'(slot_vld), 32'd0);
      chk("R9", "err in reset", 32'(err_illegal), 32'd0);
      rst = 1'b0;
      model_clear();
      exp_issue = 1'b0;
      exp_err = 1'b0;
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x ^= x << 13;
      x ^= x >> 17;
      x ^= x << 5;
      return x;
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      in_valid = 1'b0;
      in_word = '0;
      model_clear();
      exp_issue = 1'b0;
      exp_err = 1'b0;
      repeat (3) @(posedge clk);
      do_reset();
      idle();

      // R3: two simple ops take slot 0 then slot 1, closed by a branch op
      cur = "R3";
      send(mk(0, 3'd0, 32'h0000_1041));
      send(mk(0, 3'd1, 32'h0000_2082));
      send(mk(1, 3'd4, 32'h0000_30C3));
      idle();

      // R2: one op per class, full mix
      cur = "R2";
      for (int cc = 0; cc < 5; cc++) send(mk(0, 3'(cc), 32'h1357_9BDF + 32'(cc)));
      send(mk(1, 3'd3, 32'h2468_ACE0));
      idle();

      // R6: overflow of complex class splits the group
      cur = "R6";
      send(mk(0, 3'd2, 32'h0BAD_0001));
      send(mk(0, 3'd2, 32'h0BAD_0002));
      send(mk(1, 3'd0, 32'h0BAD_0003));
      idle();

      // R6 with stop on the refused word
      cur = "R6";
      send(mk(0, 3'd4, 32'h1111_1111));
      send(mk(1, 3'd4, 32'h2222_2222));
      idle();

      // R7: illegal classes take no slot
      cur = "R7";
      send(mk(0, 3'd0, 32'h0F0F_0F0F));
      send(mk(0, 3'd5, 32'h3333_3333));
      send(mk(0, 3'd6, 32'h4444_4444));
      send(mk(1, 3'd0, 32'h5555_5555));
      idle();

      // R8: illegal stop word closes group, alone or with pending ops
      cur = "R8";
      send(mk(0, 3'd3, 32'h6666_6666));
      send(mk(1, 3'd7, 32'h7777_7777));
      idle();
      send(mk(1, 3'd5, 32'h0000_0000));
      idle();

      // R10: idle cycles hold the pending group
      cur = "R10";
      send(mk(0, 3'd0, 32'h0ACE_0ACE));
      repeat (4) idle();
      send(mk(1, 3'd2, 32'h0DEF_0DEF));
      idle();

      // R9: reset in the middle of a group discards it
      cur = "R9";
      send(mk(0, 3'd0, 32'h1212_1212));
      send(mk(0, 3'd3, 32'h3434_3434));
      do_reset();
      cur = "R9";
      send(mk(1, 3'd4, 32'h5656_5656));
      idle();

      // sweep: each class code, with and without stop, overfilling each class
      cur = "R2";
      for (int cc = 0; cc < 8; cc++) begin
         for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 3; n++) begin
               lfsr = nxt(lfsr);
               send(mk(bit'(s) && (n == 2), 3'(cc), lfsr));
            end
            send(mk(1, 3'd0, nxt(lfsr)));
            idle();
         end
      end

      // pseudo-random stream with idle gaps
      cur = "R4";
      for (int n = 0; n < 5000; n++) begin
         bit a;
         lfsr = nxt(lfsr);
         if (lfsr[9:8] == 2'b00) step(1'b0, lfsr, a);
         else send({lfsr[1:0] == 2'b00, lfsr[30:0]});
      end
      idle();
      idle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule